// File: doc/BRIEF.md
# Multi-channel threshold trigger unit

The block watches three digitized signal channels and issues a single trigger order when any enabled channel's sample rises above its own programmable level. Each channel sample is compared against a per-channel threshold held in a small register bank. The per-channel hits are ORed into a raw condition. A bypass input can force that condition true with no crossing at all. The result is then blocked by an inhibit input, which the event capture logic holds while it moves a captured event out.

The gated condition is registered and edge-detected, so the output is a one-cycle pulse for each new trigger condition, not a level. Thresholds and the channel enable mask are written through a narrow register write port. The command link updates them rarely, and every update applies cleanly from the following sample on.

Top module: `mchan_trigger`

## Requirements
- R1: After reset `trig_o` is low, every threshold is 4095 and every channel is enabled, so no sample value can cause a crossing until a threshold is lowered.
- R2: A channel crosses only when its sample, taken as unsigned, is strictly greater than its threshold. A sample equal to the threshold does not cross.
- R3: A crossing on any single enabled channel is enough to trigger. Several channels crossing together still give one trigger.
- R4: Writing address 3 loads the enable mask from `cfg_wdata_i[2:0]`, with bit c controlling channel c. A disabled channel's crossings have no effect on `trig_o`.
- R5: With `bypass_i` high and `inhibit_i` low, a trigger is produced whatever the samples are.
- R6: While `inhibit_i` is high no trigger is produced. If the condition is still true when inhibit drops, a trigger follows.
- R7: `trig_o` is a single-cycle pulse on each rising edge of the gated condition. A sustained condition gives exactly one pulse.
- R8: Inputs sampled at clock edge k drive `trig_o` high in the cycle that follows edge k.
- R9: A threshold write that is strobed at edge k applies to samples taken from edge k+1 on. The sample taken at edge k is compared with the old threshold. A write produces no trigger unless the new threshold creates a real rising edge of the condition.
- R10: Writing address c (0 to 2) with `cfg_we_i` high loads `cfg_wdata_i` into the threshold of channel c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sample_i | input | 36 | Channel samples, channel c in bits [12c+11:12c] |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 2 | 0 to 2 select a threshold, 3 selects the enable mask |
| cfg_wdata_i | input | 12 | Write data |
| bypass_i | input | 1 | Force the trigger condition |
| inhibit_i | input | 1 | Block triggers |
| trig_o | output | 1 | One-cycle trigger pulse |

## Verification
The bench puts samples exactly at a threshold and one count above it. A design that compares with greater-or-equal fires one step early. It holds crossings and bypass for several cycles, which exposes a design that outputs a level instead of a pulse. It strobes a threshold write in the same cycle as a sample that lies between the old and new values, so a design that uses the new threshold too early triggers a cycle ahead. It also releases inhibit while the condition stays true and turns off a channel that is still crossing, which catch a missing edge-after-inhibit trigger and an enable mask that is ignored.

// File: rtl/trig_pkg.sv
package trig_pkg;
  localparam int unsigned DEF_CH_N  = 3;
  localparam int unsigned DEF_SMP_W = 12;

  function automatic int unsigned addr_w(input int unsigned ch_n);
    return (ch_n + 1 <= 2) ? 1 : $clog2(ch_n + 1);
  endfunction
endpackage

// File: rtl/trig_cfg_regs.sv
module trig_cfg_regs #(
  parameter int unsigned NUM_CH = 3,
  parameter int unsigned SMP_W  = 12,
  parameter int unsigned ADDR_W = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [SMP_W-1:0]          wdata_i,
  output logic [NUM_CH*SMP_W-1:0]   thr_o,
  output logic [NUM_CH-1:0]         en_o
);
  localparam logic [ADDR_W-1:0] EN_ADDR = ADDR_W'(NUM_CH);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_thr
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(c);
    logic [SMP_W-1:0] thr_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         thr_q <= '1;
      else if (we_i && addr_i == MY_ADDR)  thr_q <= wdata_i;
    end
    assign thr_o[c*SMP_W +: SMP_W] = thr_q;
  end

  logic [NUM_CH-1:0] en_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        en_q <= '1;
    else if (we_i && addr_i == EN_ADDR) en_q <= wdata_i[NUM_CH-1:0];
  end
  assign en_o = en_q;
endmodule

// File: rtl/trig_chan_cmp.sv
module trig_chan_cmp #(
  parameter int unsigned SMP_W = 12
) (
  input  logic             en_i,
  input  logic [SMP_W-1:0] smp_i,
  input  logic [SMP_W-1:0] thr_i,
  output logic             hit_o
);
  // unsigned, strictly above
  assign hit_o = en_i && (smp_i > thr_i);
endmodule

// File: rtl/trig_edge_gate.sv
module trig_edge_gate #(
  parameter int unsigned NUM_CH = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] hit_i,
  input  logic              bypass_i,
  input  logic              inhibit_i,
  output logic              trig_o
);
  logic cond_d, cond_q, trig_q;

  assign cond_d = ((|hit_i) || bypass_i) && !inhibit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cond_q <= 1'b0;
      trig_q <= 1'b0;
    end else begin
      cond_q <= cond_d;
      trig_q <= cond_d && !cond_q;
    end
  end

  assign trig_o = trig_q;
endmodule

// File: rtl/mchan_trigger.sv
module mchan_trigger
  import trig_pkg::*;
#(
  parameter int unsigned NUM_CH = DEF_CH_N,
  parameter int unsigned SMP_W  = DEF_SMP_W,
  parameter int unsigned ADDR_W = addr_w(NUM_CH)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NUM_CH*SMP_W-1:0] sample_i,
  input  logic                    cfg_we_i,
  input  logic [ADDR_W-1:0]       cfg_addr_i,
  input  logic [SMP_W-1:0]        cfg_wdata_i,
  input  logic                    bypass_i,
  input  logic                    inhibit_i,
  output logic                    trig_o
);
  logic [NUM_CH*SMP_W-1:0] thr;
  logic [NUM_CH-1:0]       en;
  logic [NUM_CH-1:0]       hit;

  trig_cfg_regs #(.NUM_CH(NUM_CH), .SMP_W(SMP_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .thr_o   (thr),
    .en_o    (en)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    trig_chan_cmp #(.SMP_W(SMP_W)) u_cmp (
      .en_i  (en[c]),
      .smp_i (sample_i[c*SMP_W +: SMP_W]),
      .thr_i (thr[c*SMP_W +: SMP_W]),
      .hit_o (hit[c])
    );
  end

  trig_edge_gate #(.NUM_CH(NUM_CH)) u_gate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hit_i     (hit),
    .bypass_i  (bypass_i),
    .inhibit_i (inhibit_i),
    .trig_o    (trig_o)
  );
endmodule

// File: rtl/mchan_trigger_chk.sv
module mchan_trigger_chk #(
  parameter int unsigned NUM_CH = 3,
  parameter int unsigned SMP_W  = 12
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [NUM_CH*SMP_W-1:0] sample_i,
  input logic                    bypass_i,
  input logic                    inhibit_i,
  input logic                    trig_o
);
  // R7
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |=> !trig_o);

  // R6
  inhibit_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inhibit_i |=> !trig_o);

  // R5
  bypass_after_inhibit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bypass_i && !inhibit_i && $past(inhibit_i)) |=> trig_o);

  // R2
  zero_sample_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_i == '0 && !bypass_i) |=> !trig_o);

  // R1
  reset_low_chk: assert property (@(posedge clk_i)
    !rst_ni |-> !trig_o);
endmodule

bind mchan_trigger mchan_trigger_chk #(.NUM_CH(NUM_CH), .SMP_W(SMP_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sample_i  (sample_i),
  .bypass_i  (bypass_i),
  .inhibit_i (inhibit_i),
  .trig_o    (trig_o)
);

// File: tb/mchan_trigger_tb.sv
module mchan_trigger_tb;
  typedef struct {
    logic  exp;
    string tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [35:0] sample = '0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [11:0] cfg_wdata = '0;
  logic        bypass = 1'b0;
  logic        inhibit = 1'b0;
  logic        trig;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  exp_t q[$];

  logic [11:0] thr_m [3];
  logic [2:0]  en_m;
  logic        prev_m;

  always #5 clk = ~clk;

  mchan_trigger u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .sample_i    (sample),
    .cfg_we_i    (cfg_we),
    .cfg_addr_i  (cfg_addr),
    .cfg_wdata_i (cfg_wdata),
    .bypass_i    (bypass),
    .inhibit_i   (inhibit),
    .trig_o      (trig)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: trig_o=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // driver: one sample cycle, model pushes the expected output of that edge
  task automatic cyc(input logic [11:0] s0, s1, s2, input logic byp, inh,
                     input string tag, input logic we = 1'b0,
                     input logic [1:0] addr = 2'd0, input logic [11:0] d = '0);
    logic [11:0] s [3];
    logic gated, any;
    exp_t e;
    @(negedge clk);
    sample = {s2, s1, s0};
    bypass = byp; inhibit = inh;
    cfg_we = we; cfg_addr = addr; cfg_wdata = d;
    s[0] = s0; s[1] = s1; s[2] = s2;
    any = 1'b0;
    for (int c = 0; c < 3; c++) if (en_m[c] && s[c] > thr_m[c]) any = 1'b1;
    gated = (any || byp) && !inh;
    e.exp = gated && !prev_m;
    e.tag = tag;
    q.push_back(e);
    prev_m = gated;
    if (we) begin
      if (addr == 2'd3) en_m = d[2:0];
      else thr_m[addr] = d;
    end
  endtask

  // monitor
  always @(posedge clk) begin
    #2;
    if (rst_n && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(trig, e.exp, e.tag);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    checks++; errors++;
    $display("FAIL watchdog: run did not complete, actual timeout expected finish");
    finish_run();
  end

  initial begin
    for (int c = 0; c < 3; c++) thr_m[c] = 12'hFFF;
    en_m = 3'b111;
    prev_m = 1'b0;
    repeat (3) @(negedge clk);
    check(trig, 1'b0, "R1 during reset");
    rst_n = 1'b1;
    // R1: max threshold, max sample: no crossing
    repeat (3) cyc(12'hFFF, 12'hFFF, 12'hFFF, 0, 0, "R1");
    cyc(0, 0, 0, 0, 0, "R8");
    // R10: program thresholds
    cyc(0, 0, 0, 0, 0, "R10", 1, 2'd0, 12'd100);
    cyc(0, 0, 0, 0, 0, "R10", 1, 2'd1, 12'd200);
    cyc(0, 0, 0, 0, 0, "R10", 1, 2'd2, 12'd300);
    // R2: equal then one above
    cyc(100, 0, 0, 0, 0, "R2 equal");
    cyc(101, 0, 0, 0, 0, "R2 above");
    // R7: sustained crossing
    repeat (3) cyc(101, 0, 0, 0, 0, "R7 hold");
    cyc(0, 0, 0, 0, 0, "R7");
    // R3: single other channels, then all together
    cyc(0, 201, 0, 0, 0, "R3 ch1");
    cyc(0, 0, 0, 0, 0, "R3");
    cyc(0, 0, 4095, 0, 0, "R3 ch2 unsigned");
    cyc(0, 0, 0, 0, 0, "R3");
    cyc(101, 201, 301, 0, 0, "R3 all");
    cyc(0, 0, 0, 0, 0, "R3");
    // R4: disable ch1
    cyc(0, 0, 0, 0, 0, "R4", 1, 2'd3, 12'b101);
    cyc(0, 500, 0, 0, 0, "R4 disabled");
    cyc(0, 500, 0, 0, 0, "R4 disabled");
    cyc(150, 500, 0, 0, 0, "R4 enabled");
    cyc(0, 0, 0, 0, 0, "R4");
    // R4: disable ch0 while it crosses, then re-enable
    cyc(150, 0, 0, 0, 0, "R4");
    cyc(150, 0, 0, 0, 0, "R4", 1, 2'd3, 12'b110);
    cyc(150, 0, 0, 0, 0, "R4 off");
    cyc(150, 0, 0, 0, 0, "R4", 1, 2'd3, 12'b111);
    cyc(150, 0, 0, 0, 0, "R4 back on");
    cyc(0, 0, 0, 0, 0, "R4");
    // R5: bypass with no crossing
    cyc(0, 0, 0, 1, 0, "R5 bypass");
    cyc(0, 0, 0, 1, 0, "R5 held");
    cyc(0, 0, 0, 0, 0, "R5");
    // R6: inhibit blocks, trigger on release
    cyc(0, 0, 0, 1, 1, "R6 inhibited");
    cyc(101, 0, 0, 1, 1, "R6 inhibited");
    cyc(101, 0, 0, 1, 0, "R6 release");
    cyc(101, 0, 0, 0, 0, "R6");
    cyc(0, 0, 0, 0, 0, "R6");
    cyc(0, 210, 0, 0, 1, "R6 crossing inhibited");
    cyc(0, 0, 0, 0, 0, "R6");
    // R9: write coinciding with a sample between old and new threshold
    cyc(0, 0, 250, 0, 0, "R9 old thr", 1, 2'd2, 12'd200);
    cyc(0, 0, 250, 0, 0, "R9 new thr");
    cyc(0, 0, 250, 0, 0, "R9 hold");
    // R9: raising threshold above a held sample, then lowering, no extra pulse
    cyc(0, 0, 250, 0, 0, "R9", 1, 2'd2, 12'd260);
    cyc(0, 0, 250, 0, 0, "R9 raised");
    cyc(0, 0, 250, 0, 0, "R9", 1, 2'd2, 12'd240);
    cyc(0, 0, 250, 0, 0, "R9 lowered");
    cyc(0, 0, 0, 0, 0, "R8");
    cyc(0, 0, 0, 0, 0, "R8");
    @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule